// File: doc/BRIEF.md
# Three-Wire Panel Register Master

This block carries out one register access at a time to a display controller that is configured over a three-wire serial link. The link has an active-high enable strobe, a serial clock and one data line that changes direction. A host pulses `start_i` with a read/write flag, a 6-bit register address and, for writes, 8 bits of data. The block then frames a 16-pulse transfer. Six address pulses go first, most significant bit first. Next comes one direction pulse, then one turnaround pulse, and last eight data pulses. On a read, the block releases the data line for the turnaround and data pulses and collects the controller's reply.

All link timing comes from the system clock. Five parameters set five things in system clock cycles: the strobe lead time, the data setup before each clock rise, the clock high time, the clock low time and the minimum strobe-low recovery gap. The defaults suit a 200 MHz system clock: about 150 ns setup, 160 ns high and low, and 1 µs recovery. The data pad is not part of this block. It drives out `sdo_o` with the enable `sdo_oe_o` and reads the line back on `sdi_i`.

`busy_o` stays high for the whole transfer and for the recovery gap. A one-cycle `done_o` marks the return to idle. Read data appears on `rdata_o` in that same cycle.

Top module: `tw_panel_master`

## Requirements
- R1: After reset, and whenever idle, `sen_o`, `sclk_o` and `sdo_o` are 0, `sdo_oe_o` is 1 and `busy_o` is 0. Just after reset, `done_o` is 0 and `rdata_o` is 0.
- R2: A `start_i` pulse that arrives while `busy_o` is 1 is ignored. It starts no extra frame and changes neither the frame in progress nor `rdata_o`.
- R3: Every transaction has exactly 16 rising edges of `sclk_o`, and `sclk_o` is only ever 1 while `sen_o` is 1.
- R4: Pulses 1 to 6 carry the address, most significant bit first. Pulse 7 carries the direction bit, with 0 for a write and 1 for a read.
- R5: On a write, `sdo_oe_o` is 1 at all 16 pulses, pulse 8 (turnaround) carries 0, and pulses 9 to 16 carry the write data, most significant bit first.
- R6: On a read, `sdo_oe_o` goes to 0 during the setup phase of pulse 8 and stays 0 through pulse 16. `sdi_i` is sampled in the last system cycle before each of pulses 9 to 16, and the samples fill `rdata_o` most significant bit first.
- R7: `sclk_o` stays high for exactly HIGH_CYC cycles. Between two pulses it stays low for exactly LOW_CYC+SETUP_CYC cycles. `sdo_o` and `sdo_oe_o` hold their values for at least SETUP_CYC cycles before each rise and do not change while `sclk_o` is high.
- R8: `sen_o` is high for exactly LEAD_CYC+SETUP_CYC cycles before the first rise of `sclk_o`.
- R9: After the last pulse, `sdo_oe_o` is 1 and `sdo_o` is 0 while `sen_o` is still high. After `sen_o` falls, it stays low for at least GAP_CYC cycles before it can rise again.
- R10: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle. `rdata_o` changes only in a cycle where `done_o` is 1, and only when a read finishes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transaction (taken only when idle) |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, updated at done of a read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transaction or recovery gap in progress |
| sen_o | output | 1 | Serial enable strobe |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out to the pad |
| sdo_oe_o | output | 1 | Data pad output enable (0 = released) |
| sdi_i | input | 1 | Serial data in from the pad |

## Verification
The bench models a controller with 64 byte-wide registers. It runs a table of writes and reads over the address extremes 0x00 and 0x3F and over data patterns 0x55, 0xA5, 0x00 and 0xFF. These patterns show whether bit order, address bits and data bits are kept apart and not swapped or stuck. Reading a register that was never written returns the model's preset value, which rules out any path that echoes the last write. Writes placed between reads show whether `rdata_o` holds across a write. A second start during a running frame shows whether requests that overlap are dropped.

// File: rtl/tw_panel_pkg.sv
package tw_panel_pkg;

    // Frame layout is fixed by the link: address, direction, turnaround, data.
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 8;
    localparam int FRAME_W  = ADDR_W + 2 + DATA_W;
    localparam int TURN_IDX = ADDR_W + 1;     // pulse index of the turnaround slot
    localparam int DATA_IDX = ADDR_W + 2;     // pulse index of the first data bit
    localparam int BIT_W    = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SETUP,
        PH_HIGH,
        PH_LOW,
        PH_TAIL,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    // Serial image of a request, first bit to leave in the MSB.
    function automatic logic [FRAME_W-1:0] frame_of(input req_t r);
        return {r.addr, r.rd, 1'b0, r.wdata};
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/tw_frame_shifter.sv
module tw_frame_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb_o
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb_o = sr[W-1];
endmodule

// File: rtl/tw_rx_capture.sv
module tw_rx_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data_o <= '0;
        end else if (sample) begin
            data_o <= {data_o[W-2:0], din};
        end
    end
endmodule

// File: rtl/tw_panel_master.sv
module tw_panel_master
    import tw_panel_pkg::*;
#(
    parameter int LEAD_CYC  = 30,   // strobe-only time before the first setup phase (>=1)
    parameter int SETUP_CYC = 30,   // data valid before each clock rise (>=1)
    parameter int HIGH_CYC  = 32,   // clock high time (>=1)
    parameter int LOW_CYC   = 32,   // clock low time after a pulse (>=1)
    parameter int GAP_CYC   = 200   // strobe low recovery (>=1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic [5:0]  addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        done_o,
    output logic        busy_o,
    output logic        sen_o,
    output logic        sclk_o,
    output logic        sdo_o,
    output logic        sdo_oe_o,
    input  logic        sdi_i
);
    localparam int MAX_C = max_i(max_i(max_i(LEAD_CYC, SETUP_CYC),
                                       max_i(HIGH_CYC, LOW_CYC)), GAP_CYC);
    localparam int CW = $clog2(MAX_C) + 1;

    localparam logic [BIT_W-1:0] LAST_B = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] TURN_B = BIT_W'(TURN_IDX);
    localparam logic [BIT_W-1:0] DATA_B = BIT_W'(DATA_IDX);

    localparam logic [CW-1:0] LEAD_LD  = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HIGH_LD  = CW'(HIGH_CYC - 1);
    localparam logic [CW-1:0] LOW_LD   = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYC - 1);

    phase_e             ph, ph_n;
    logic               rd_q;
    logic [BIT_W-1:0]   bit_idx;
    logic               tmr_load, tmr_exp;
    logic [CW-1:0]      tmr_val;
    logic               sh_load, sh_shift, sh_msb;
    logic               rx_clear, rx_sample;
    logic [DATA_W-1:0]  rx_data;
    logic               finish;
    logic               line_active, released;
    logic [7:0]         rdata_q;
    logic               done_q;
    req_t               req_in;

    assign req_in = '{rd: rd_i, addr: addr_i, wdata: wdata_i};

    // Phase sequencing: one shared timer is reloaded at every phase change.
    always_comb begin
        ph_n      = ph;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        rx_clear  = 1'b0;
        rx_sample = 1'b0;
        finish    = 1'b0;
        unique case (ph)
            PH_IDLE: if (start_i) begin
                ph_n     = PH_LEAD;
                tmr_load = 1'b1;
                tmr_val  = LEAD_LD;
                sh_load  = 1'b1;
                rx_clear = 1'b1;
            end
            PH_LEAD: if (tmr_exp) begin
                ph_n     = PH_SETUP;
                tmr_load = 1'b1;
                tmr_val  = SETUP_LD;
            end
            PH_SETUP: if (tmr_exp) begin
                ph_n      = PH_HIGH;
                tmr_load  = 1'b1;
                tmr_val   = HIGH_LD;
                rx_sample = rd_q && (bit_idx >= DATA_B);
            end
            PH_HIGH: if (tmr_exp) begin
                ph_n     = PH_LOW;
                tmr_load = 1'b1;
                tmr_val  = LOW_LD;
            end
            PH_LOW: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (bit_idx == LAST_B) begin
                    ph_n    = PH_TAIL;
                    tmr_val = '0;
                end else begin
                    ph_n     = PH_SETUP;
                    tmr_val  = SETUP_LD;
                    sh_shift = 1'b1;
                end
            end
            PH_TAIL: if (tmr_exp) begin
                ph_n     = PH_GAP;
                tmr_load = 1'b1;
                tmr_val  = GAP_LD;
            end
            PH_GAP: if (tmr_exp) begin
                ph_n   = PH_IDLE;
                finish = 1'b1;
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            rd_q    <= 1'b0;
            bit_idx <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            ph     <= ph_n;
            done_q <= finish;
            if (sh_load) begin
                rd_q    <= rd_i;
                bit_idx <= '0;
            end else if (sh_shift) begin
                bit_idx <= bit_idx + 1'b1;
            end
            if (finish && rd_q) begin
                rdata_q <= rx_data;
            end
        end
    end

    tw_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    tw_frame_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (frame_of(req_in)),
        .shift    (sh_shift),
        .msb_o    (sh_msb)
    );

    tw_rx_capture #(.W(DATA_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (rx_clear),
        .sample (rx_sample),
        .din    (sdi_i),
        .data_o (rx_data)
    );

    // Pad control: the line is released from the turnaround setup onward on reads.
    assign line_active = (ph == PH_LEAD) || (ph == PH_SETUP) ||
                         (ph == PH_HIGH) || (ph == PH_LOW);
    assign released    = rd_q && (bit_idx >= TURN_B) &&
                         ((ph == PH_SETUP) || (ph == PH_HIGH) || (ph == PH_LOW));

    assign sen_o    = line_active || (ph == PH_TAIL);
    assign sclk_o   = (ph == PH_HIGH);
    assign sdo_oe_o = !released;
    assign sdo_o    = line_active && !released && sh_msb;
    assign busy_o   = (ph != PH_IDLE);
    assign done_o   = done_q;
    assign rdata_o  = rdata_q;
endmodule

// File: rtl/tw_panel_master_chk.sv
module tw_panel_master_chk #(
    parameter int HIGH_CYC = 32,
    parameter int GAP_CYC  = 200
) (
    input logic       clk,
    input logic       rst,
    input logic       sen_o,
    input logic       sclk_o,
    input logic       sdo_o,
    input logic       sdo_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] rdata_o
);
    int unsigned hi_cnt;
    int unsigned gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= 0;
            gap_cnt <= GAP_CYC;
        end else begin
            hi_cnt <= sclk_o ? hi_cnt + 1 : 0;
            if (sen_o) begin
                gap_cnt <= 0;
            end else if (gap_cnt < GAP_CYC) begin
                gap_cnt <= gap_cnt + 1;
            end
        end
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!sen_o && !sclk_o && !sdo_o && sdo_oe_o));

    p_clk_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> sen_o);

    p_hold_while_high_r7: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> ($stable(sdo_o) && $stable(sdo_oe_o)));

    p_high_width_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> (hi_cnt == HIGH_CYC));

    p_tail_drive_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(sen_o) |-> ($past(sdo_oe_o) && !$past(sdo_o)));

    p_recovery_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sen_o) |-> (gap_cnt >= GAP_CYC));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_rdata_at_done_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata_o) |-> done_o);
endmodule

bind tw_panel_master tw_panel_master_chk #(
    .HIGH_CYC (HIGH_CYC),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sen_o    (sen_o),
    .sclk_o   (sclk_o),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rdata_o  (rdata_o)
);

// File: tb/tw_panel_master_tb.sv
module tw_panel_master_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LEAD  = 5;
    localparam int SETUP = 3;
    localparam int HIGH  = 4;
    localparam int LOW   = 4;
    localparam int GAP   = 10;
    localparam int NVEC  = 11;

    // {rd, addr, wdata, expected read data}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 6'h00, 8'h55, 8'h00},
        {1'b1, 6'h00, 8'h00, 8'h55},
        {1'b0, 6'h3F, 8'hA5, 8'h00},
        {1'b0, 6'h03, 8'h01, 8'h00},
        {1'b1, 6'h3F, 8'h00, 8'hA5},
        {1'b1, 6'h03, 8'h00, 8'h01},
        {1'b1, 6'h01, 8'h00, 8'h04},
        {1'b0, 6'h2A, 8'h00, 8'h00},
        {1'b1, 6'h2A, 8'hFF, 8'h00},
        {1'b0, 6'h15, 8'hFF, 8'h00},
        {1'b1, 6'h15, 8'h00, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [5:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       done_o, busy_o, sen_o, sclk_o, sdo_o, sdo_oe_o;
    logic       sdi_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    tw_panel_master #(
        .LEAD_CYC (LEAD), .SETUP_CYC (SETUP), .HIGH_CYC (HIGH),
        .LOW_CYC (LOW), .GAP_CYC (GAP)
    ) u_dut (
        .clk (clk), .rst (rst), .start_i (start_i), .rd_i (rd_i),
        .addr_i (addr_i), .wdata_i (wdata_i), .rdata_o (rdata_o),
        .done_o (done_o), .busy_o (busy_o), .sen_o (sen_o), .sclk_o (sclk_o),
        .sdo_o (sdo_o), .sdo_oe_o (sdo_oe_o), .sdi_i (sdi_i)
    );

    // ---------------- panel model and link monitor ----------------
    logic [7:0]  mem [64];
    logic        p_sen, p_sclk, p_sdo, p_oe;
    logic [15:0] bits, oev;
    logic [5:0]  cur_addr;
    logic        cur_dir;
    int nrise, lead, hi_len, lo_len, stab, stab_b, sen_low;
    int frames = 0;
    int f_nrise, f_lead;
    logic [5:0]  f_addr;
    logic        f_dir;
    logic [7:0]  f_data;
    logic [15:0] f_oe;
    int e_setup = 0, e_hi = 0, e_lo = 0, e_tail = 0, e_gap = 0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 3 + 1);
    end

    always @(negedge clk) begin
        if (rst) begin
            p_sen = 0; p_sclk = 0; p_sdo = 0; p_oe = 1;
            stab = 0; sen_low = 1000; sdi_i = 0; nrise = 0;
            cur_dir = 0; cur_addr = 0;
        end else begin
            stab_b = stab;
            if ({sdo_o, sdo_oe_o} != {p_sdo, p_oe}) stab = 1; else stab = stab + 1;
            if (sen_o && !p_sen) begin
                if (frames > 0 && sen_low < GAP) e_gap++;
                nrise = 0; lead = 0; lo_len = 0; hi_len = 0;
                bits = '0; oev = '0; cur_dir = 0; cur_addr = 0;
            end
            if (sen_o && !sclk_o && nrise == 0) lead++;
            if (sclk_o) begin
                if (!p_sclk) begin
                    if (stab_b < SETUP || {sdo_o, sdo_oe_o} != {p_sdo, p_oe}) e_setup++;
                    if (nrise == 0) f_lead = lead;
                    else if (lo_len != LOW + SETUP) e_lo++;
                    bits = {bits[14:0], sdo_o};
                    oev  = {oev[14:0], sdo_oe_o};
                    if (nrise == 5) cur_addr = bits[5:0];
                    if (nrise == 6) cur_dir = sdo_o;
                    nrise++;
                    hi_len = 0;
                end
                hi_len++;
            end else begin
                if (p_sclk) begin
                    if (hi_len != HIGH) e_hi++;
                    lo_len = 0;
                end
                lo_len++;
            end
            if (!sen_o && p_sen) begin
                if (!(p_oe && !p_sdo)) e_tail++;
                frames++;
                f_nrise = nrise; f_addr = bits[15:10]; f_dir = bits[9];
                f_data = bits[7:0]; f_oe = oev;
                if (!bits[9] && nrise == 16) mem[bits[15:10]] = bits[7:0];
                sen_low = 0;
            end
            if (!sen_o) sen_low++;
            sdi_i = (sen_o && cur_dir && nrise >= 8 && nrise <= 15)
                    ? mem[cur_addr][3'(15 - nrise)] : 1'b0;
            p_sen = sen_o; p_sclk = sclk_o; p_sdo = sdo_o; p_oe = sdo_oe_o;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        int n = 0;
        seen = 1'b0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        seen = done_o;
    endtask

    task automatic run_txn(input logic rd, input logic [5:0] a, input logic [7:0] d);
        bit seen;
        @(negedge clk);
        start_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        chk(seen, "R10 done reached", int'(seen), 1);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] last_rd;
        bit seen;
        int f0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk({sen_o, sclk_o, sdo_o} == 3'b000, "R1 lines low after reset", {sen_o, sclk_o, sdo_o}, 0);
        chk(sdo_oe_o == 1'b1, "R1 oe high after reset", sdo_oe_o, 1);
        chk(!busy_o && !done_o, "R1 busy/done low after reset", {busy_o, done_o}, 0);
        chk(rdata_o == 8'h00, "R1 rdata zero after reset", rdata_o, 0);

        last_rd = 8'h00;
        for (int v = 0; v < NVEC; v++) begin
            logic       rd;
            logic [5:0] a;
            logic [7:0] d, e;
            {rd, a, d, e} = VEC[v];
            f0 = frames;
            run_txn(rd, a, d);
            chk(!busy_o, "R10 busy low at done", busy_o, 0);
            chk(!sen_o && !sclk_o && !sdo_o && sdo_oe_o, "R1 idle lines at done",
                {sen_o, sclk_o, sdo_o, sdo_oe_o}, 1);
            chk(frames == f0 + 1, "R3 one frame per request", frames - f0, 1);
            chk(f_nrise == 16, "R3 pulse count", f_nrise, 16);
            chk(f_addr == a, "R4 address bits", f_addr, a);
            chk(f_dir == rd, "R4 direction bit", f_dir, rd);
            chk(f_lead == LEAD + SETUP, "R8 strobe lead", f_lead, LEAD + SETUP);
            if (rd) begin
                chk(f_oe == 16'hFE00, "R6 release pattern", f_oe, 16'hFE00);
                chk(rdata_o == e, "R6 read data", rdata_o, e);
                last_rd = e;
            end else begin
                chk(f_oe == 16'hFFFF, "R5 driven pattern", f_oe, 16'hFFFF);
                chk(f_data == d, "R5 write data", f_data, d);
                chk(rdata_o == last_rd, "R10 rdata held on write", rdata_o, last_rd);
            end
            @(negedge clk);
            chk(!done_o, "R10 done single cycle", done_o, 0);
        end

        chk(e_setup == 0, "R7 setup/stability errors", e_setup, 0);
        chk(e_hi == 0, "R7 high width errors", e_hi, 0);
        chk(e_lo == 0, "R7 low width errors", e_lo, 0);
        chk(e_tail == 0, "R9 tail drive errors", e_tail, 0);
        chk(e_gap == 0, "R9 recovery gap errors", e_gap, 0);

        // R2: start during a running transaction is ignored
        f0 = frames;
        @(negedge clk);
        start_i = 1'b1; rd_i = 1'b0; addr_i = 6'h10; wdata_i = 8'h11;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1; rd_i = 1'b0; addr_i = 6'h20; wdata_i = 8'h22;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        chk(seen, "R2 first transfer completes", int'(seen), 1);
        repeat (3 * GAP + 20) @(negedge clk);
        chk(frames == f0 + 1, "R2 extra start ignored", frames - f0, 1);
        chk(f_addr == 6'h10 && f_data == 8'h11, "R2 frame unchanged", {f_addr, f_data}, {6'h10, 8'h11});
        chk(mem[6'h20] == 8'(32 * 3 + 1), "R2 no write to second address", mem[6'h20], 8'(32 * 3 + 1));
        chk(!busy_o, "R2 idle afterwards", busy_o, 0);
        chk(rdata_o == last_rd, "R2 rdata untouched", rdata_o, last_rd);
        chk(e_gap == 0 && e_tail == 0, "R9 after overlap test", e_gap + e_tail, 0);

        finish_run();
    end
endmodule